// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave (256 x 8)

This block is a synthesizable two-wire serial memory slave with 256 bytes of storage. The whole block runs on one system clock. The SCL, SDA and write-control pins are passed through synchronizers, and the START, STOP and SCL-edge events are taken from the synchronized samples. The block answers a 7-bit select code: the fixed family nibble `1010` followed by a 3-bit chip strap. It supports byte writes, page writes that gather up to eight bytes, random reads, current-address reads and sequential reads.

The block drives SDA through a single pull-low output, and the pad is open drain. Written bytes first go into a page staging buffer. The STOP that closes a write starts a timed internal write cycle. The staged bytes reach the array only when that cycle ends. For the whole cycle the slave ignores the bus, so a master polls for completion by sending a select code until it is acknowledged. When the write-control input is high at the STOP, the staged bytes are dropped. The bus interface is the two-wire protocol itself, so no valid/ready handshake is involved.

Top module: `ee_slave`

## Requirements
- R1: After reset, every memory location reads 0xFF and the SDA pull output is released (0).
- R2: The select byte is sent MSB first. Bits 7..4 must be 1010, bits 3..1 must equal `chip_sel_i`, and bit 0 is read (1) or write (0). A matching select byte is acknowledged by pulling SDA low during the ninth clock. A non-matching select byte is not acknowledged, and the slave drives nothing until the next START.
- R3: A byte write is a write select, then a word address, then one data byte, then STOP. The data byte is stored at that address once the internal write cycle has finished.
- R4: In a page write, each data byte goes to the current address. After each byte, the low 3 address bits step up and wrap within the 8-byte page. A byte written later to the same location replaces the earlier one.
- R5: A random read is a write select, then a word address, then a repeated START and a read select. It returns the byte stored at that address, MSB first.
- R6: In a sequential read, each master acknowledge moves the address up by one, wrapping from 0xFF to 0x00. A later current-address read continues from the address after the last byte read.
- R7: After a master no-acknowledge, the slave releases SDA and drives nothing until the next START.
- R8: For `WRITE_CYCLES` clocks after a STOP that ends a write carrying data, the slave ignores the bus. During this time a select byte is not acknowledged and the array still holds its old contents.
- R9: If `wr_ctrl_i` is high at the STOP, no write cycle starts. The memory is unchanged, and the next select byte is acknowledged at once.
- R10: A write that carries only a word address and then STOP starts no write cycle. It still sets the current address.
- R11: The slave changes its SDA pull output only while SCL is low, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain driver enable) |
| chip_sel_i | input | 3 | Chip strap compared with select bits 3..1 |
| wr_ctrl_i | input | 1 | 1 blocks internal write cycles |

## Verification
The bench builds the block with the default 256-byte array and 8-byte page, so both the page wrap inside a page and the address wrap from 0xFF to 0x00 can be reached with short transfers. `WRITE_CYCLES` is set to 300. That is longer than one select byte on the bus, so a completion poll sent right after STOP falls inside the busy window, and it is short enough that several committed writes fit in the run. The chip strap is tied to 101, so a select byte carrying 000 exercises the mismatch path.

// File: rtl/ee_slave_pkg.sv
package ee_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_MACK
  } ee_state_t;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic scl_s,
  output logic sda_s,
  output logic wp_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int unsigned NCH = 3;
  localparam logic [NCH-1:0] RST_VAL = 3'b011;

  logic [NCH-1:0] raw;
  logic [NCH-1:0] st [SYNC_STAGES];
  logic scl_q, sda_q;

  assign raw = {wp_i, sda_i, scl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) st[k] <= RST_VAL;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      st[0] <= raw;
      for (int k = 1; k < SYNC_STAGES; k++) st[k] <= st[k-1];
      scl_q <= st[SYNC_STAGES-1][0];
      sda_q <= st[SYNC_STAGES-1][1];
    end
  end

  assign scl_s    = st[SYNC_STAGES-1][0];
  assign sda_s    = st[SYNC_STAGES-1][1];
  assign wp_s     = st[SYNC_STAGES-1][2];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_wtimer.sv
module ee_wtimer #(
  parameter int unsigned CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        cnt    <= CW'(CYCLES - 1);
      end else if (busy_o) begin
        if (cnt == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R8: completion pulse only at the end of a busy window
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned PAGE  = 8,
  parameter int unsigned DW    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              buf_we_i,
  input  logic [$clog2(PAGE)-1:0]           buf_idx_i,
  input  logic [DW-1:0]                     buf_data_i,
  input  logic                              clr_pend_i,
  input  logic                              commit_i,
  input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_sel_i,
  input  logic [$clog2(DEPTH)-1:0]          rd_addr_i,
  output logic [DW-1:0]                     rd_data_o,
  output logic                              pending_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = $clog2(PAGE);

  logic [DW-1:0]   mem  [DEPTH];
  logic [DW-1:0]   pbuf [PAGE];
  logic [PAGE-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else if (commit_i || clr_pend_i) begin
      mask <= '0;
    end else if (buf_we_i) begin
      pbuf[buf_idx_i] <= buf_data_i;
      mask[buf_idx_i] <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [AW-PW-1:0] PG = (AW-PW)'(g / PAGE);
    localparam int unsigned IX = g % PAGE;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '1;
      else if (commit_i && mask[IX] && page_sel_i == PG) mem[g] <= pbuf[IX];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
  assign pending_o = |mask;

  // R3: staging and committing never overlap; commit only with staged data
  assert_commit_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_we_i && commit_i));
  assert_commit_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> pending_o);
endmodule

// File: rtl/ee_slave.sv
module ee_slave
  import ee_slave_pkg::*;
#(
  parameter int unsigned MEM_DEPTH    = 256,
  parameter int unsigned PAGE_BYTES   = 8,
  parameter int unsigned WRITE_CYCLES = 5000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] chip_sel_i,
  input  logic       wr_ctrl_i
);
  localparam int unsigned AW = $clog2(MEM_DEPTH);
  localparam int unsigned PW = $clog2(PAGE_BYTES);
  localparam int unsigned DW = 8;

  logic scl_s, sda_s, wp_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, done, pending, wr_start, buf_we, clr_pend;
  logic [DW-1:0] rd_data;

  ee_state_t     state;
  logic [2:0]    bit_cnt;
  logic [DW-1:0] rx;
  logic [DW-2:0] tx;
  logic          byte_full, in_ack, rd_mode, mack;
  logic [AW-1:0] ptr;
  logic          sel_match;

  ee_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wr_ctrl_i),
    .scl_s(scl_s), .sda_s(sda_s), .wp_s(wp_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  ee_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(wr_start), .busy_o(busy), .done_o(done)
  );

  ee_store #(.DEPTH(MEM_DEPTH), .PAGE(PAGE_BYTES), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_we_i(buf_we), .buf_idx_i(ptr[PW-1:0]),
    .buf_data_i(rx), .clr_pend_i(clr_pend), .commit_i(done),
    .page_sel_i(ptr[AW-1:PW]), .rd_addr_i(ptr), .rd_data_o(rd_data),
    .pending_o(pending)
  );

  assign sel_match = (rx[7:1] == {DEV_FAMILY, chip_sel_i});
  assign clr_pend  = start_ev && !busy;
  assign wr_start  = stop_ev && !busy && pending && !wp_s;
  assign buf_we    = !busy && !start_ev && !stop_ev && state == ST_WDATA &&
                     scl_fall && byte_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bit_cnt <= '0; rx <= '0; tx <= '0;
      byte_full <= 1'b0; in_ack <= 1'b0; rd_mode <= 1'b0; mack <= 1'b0;
      ptr <= '0; sda_pull_o <= 1'b0;
    end else if (busy) begin
      state <= ST_IDLE; sda_pull_o <= 1'b0; in_ack <= 1'b0; byte_full <= 1'b0;
    end else if (start_ev) begin
      state <= ST_DEV; bit_cnt <= '0; byte_full <= 1'b0; in_ack <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE; sda_pull_o <= 1'b0; in_ack <= 1'b0; byte_full <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && !byte_full && !in_ack) begin
            rx <= {rx[DW-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) byte_full <= 1'b1;
          end else if (scl_fall && byte_full) begin
            byte_full <= 1'b0;
            if (state == ST_DEV && !sel_match) begin
              state <= ST_IDLE;
            end else begin
              sda_pull_o <= 1'b1;
              in_ack <= 1'b1;
              if (state == ST_DEV)   rd_mode <= rx[0];
              if (state == ST_ADDR)  ptr <= rx[AW-1:0];
              if (state == ST_WDATA) ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
            end
          end else if (scl_fall && in_ack) begin
            in_ack <= 1'b0;
            bit_cnt <= '0;
            if (state == ST_DEV && rd_mode) begin
              state <= ST_RDATA;
              tx <= rd_data[DW-2:0];
              sda_pull_o <= ~rd_data[DW-1];
            end else begin
              sda_pull_o <= 1'b0;
              state <= (state == ST_DEV) ? ST_ADDR : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              state <= ST_MACK;
              sda_pull_o <= 1'b0;
              ptr <= ptr + 1'b1;
            end else begin
              sda_pull_o <= ~tx[DW-2];
              tx <= {tx[DW-3:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              state <= ST_RDATA;
              bit_cnt <= '0;
              tx <= rd_data[DW-2:0];
              sda_pull_o <= ~rd_data[DW-1];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R11: the data line moves only with SCL low, or on a bus condition
  assert_pull_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> (!$past(scl_s) || $past(start_ev || stop_ev)));
  // R8: silent while the internal write runs
  assert_quiet_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);
  // R9: write control held high at STOP keeps the timer idle
  assert_wp_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !busy && wp_s) |=> !busy);
  // R10: a STOP without staged data never starts a write cycle
  assert_no_empty_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !busy && !pending) |=> !busy);
endmodule

// File: tb/ee_slave_tb.sv
module ee_slave_tb;
  localparam int WCYC = 300;
  localparam int Q    = 5;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_pull;
  logic line;
  int vectors = 0, errors = 0;
  logic [7:0] mem_m [256];
  logic [7:0] ptr_m = 8'h00;
  logic prev_scl = 1'b1, prev_pull = 1'b0;
  logic done_flag = 1'b0;

  always #5 clk = ~clk;
  assign line = sda_m & ~sda_pull;

  ee_slave #(.WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line),
    .sda_pull_o(sda_pull), .chip_sel_i(CS), .wr_ctrl_i(wp)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // R11: per-clock comparison, pull must hold while SCL stays high
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (scl_m && prev_scl) chk("R11 pull stable while SCL high", sda_pull, prev_pull);
      prev_scl  = scl_m;
      prev_pull = sda_pull;
    end
  end

  task automatic qw(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw(); endtask
  task automatic bus_stop(); sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw(); endtask
  task automatic bit_out(input logic b); sda_m = b; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw(); endtask
  task automatic bit_in(output logic b); sda_m = 1; qw(); scl_m = 1; qw(); b = line; qw(); scl_m = 0; qw(); endtask

  task automatic wr_byte(input logic [7:0] d, input logic exp_ack, input string req);
    logic g;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(g);
    chk(req, !g, exp_ack);
  endtask

  task automatic rd_byte(input logic [7:0] exp, input logic ack, input string req);
    logic [7:0] got;
    logic g;
    for (int i = 7; i >= 0; i--) begin bit_in(g); got[i] = g; end
    chk(req, got, exp);
    bit_out(!ack);
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [7:0] d[$], input logic wait_done, input string req);
    int idx;
    bus_start();
    wr_byte({4'b1010, CS, 1'b0}, 1, req);
    wr_byte(addr, 1, req);
    foreach (d[k]) wr_byte(d[k], 1, req);
    bus_stop();
    idx = addr[2:0];
    foreach (d[k]) begin
      if (!wp) mem_m[{addr[7:3], 3'(idx)}] = d[k];
      idx = (idx + 1) % 8;
    end
    ptr_m = {addr[7:3], 3'(idx)};
    if (wait_done && d.size() > 0 && !wp) repeat (WCYC + 20) @(negedge clk);
  endtask

  task automatic rd_seq(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      rd_byte(mem_m[ptr_m], k != n - 1, req);
      ptr_m = ptr_m + 8'd1;
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n, input string req);
    bus_start();
    wr_byte({4'b1010, CS, 1'b0}, 1, req);
    wr_byte(addr, 1, req);
    ptr_m = addr;
    bus_start();
    wr_byte({4'b1010, CS, 1'b1}, 1, req);
    rd_seq(n, req);
  endtask

  task automatic cur_read(input int n, input string req);
    bus_start();
    wr_byte({4'b1010, CS, 1'b1}, 1, req);
    rd_seq(n, req);
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d[$];
    logic g;
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pull released after reset", sda_pull, 0);
    rand_read(8'h00, 3, "R1 R5 erased contents");

    d = '{8'h5A};
    do_write(8'h10, d, 1, "R3 byte write");
    rand_read(8'h10, 1, "R3 R5 byte readback");

    // R8: poll during the write cycle
    d = '{8'h11};
    do_write(8'h20, d, 0, "R8 write before poll");
    bus_start();
    wr_byte({4'b1010, CS, 1'b1}, 0, "R8 busy select not acked");
    bus_stop();
    repeat (WCYC + 20) @(negedge clk);
    rand_read(8'h20, 1, "R8 data after write cycle");

    d = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    do_write(8'h45, d, 1, "R4 page write wrap");
    rand_read(8'h40, 8, "R4 R6 page contents");

    d = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hA8, 8'hA9};
    do_write(8'h80, d, 1, "R4 page overrun");
    rand_read(8'h80, 8, "R4 overrun contents");

    rand_read(8'hFE, 4, "R6 sequential wrap");
    cur_read(1, "R6 current address continues");

    // R2: mismatching strap, then wrong family
    bus_start();
    wr_byte({4'b1010, 3'b000, 1'b1}, 0, "R2 strap mismatch not acked");
    wr_byte(8'h00, 0, "R2 silent after mismatch");
    bus_stop();
    bus_start();
    wr_byte({4'b0110, CS, 1'b0}, 0, "R2 family mismatch not acked");
    bus_stop();

    wp = 1'b1;
    d = '{8'h77};
    do_write(8'h30, d, 1, "R9 protected write acked");
    bus_start();
    wr_byte({4'b1010, CS, 1'b1}, 1, "R9 no busy after protected STOP");
    rd_byte(mem_m[ptr_m], 0, "R9 current read");
    ptr_m = ptr_m + 8'd1;
    bus_stop();
    wp = 1'b0;
    rand_read(8'h30, 1, "R9 memory unchanged");

    d = {};
    do_write(8'h45, d, 1, "R10 address only");
    cur_read(1, "R10 pointer set, no busy");

    // R7: after NACK the slave stays off the line
    rand_read(8'h10, 1, "R7 read before nack");
    bus_start();
    wr_byte({4'b1010, CS, 1'b1}, 1, "R7 select");
    rd_byte(mem_m[ptr_m], 0, "R7 byte with nack");
    ptr_m = ptr_m + 8'd1;
    begin
      logic [7:0] got;
      for (int i = 7; i >= 0; i--) begin bit_in(g); got[i] = g; end
      chk("R7 line released after nack", got, 8'hFF);
    end
    bus_stop();

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule